// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill Control

This block holds a processor's integer registers as a ring of overlapping windows plus a small bank of globals. A current-window pointer chooses which window the instruction's register numbers land in. A call moves the pointer forward one window and a return moves it back. Register numbers form one flat 5-bit space. The low group reaches the globals whatever the pointer is. The other three groups reach the incoming, local and outgoing registers of the current window. The outgoing group of one window is the same storage as the incoming group of the next, so arguments pass with no copying.

The ring has a fixed number of windows, so the controller counts how many are resident. A call that would overwrite the incoming registers of the oldest resident frame raises an overflow trap. The block then streams that frame out one register per cycle, waits for an acknowledge, and only then completes the call. A return into a frame that was already streamed out raises an underflow trap. The block accepts the frame back through a write port, waits for an acknowledge, and then completes the return. Moving the data to memory is left to an outside agent, which sees only the window index, a register offset and the data.

The pipeline uses two combinational read ports and one synchronous write port.

Top module: `regwin_file`

## Requirements
- R1: After reset the current-window pointer is 0, the saved-window pointer is NWIN-1, no trap or stall is raised and every register reads as zero.
- R2: Logical registers 0 to 7 reach the same eight global registers in every window.
- R3: Logical registers 24 to 31 of window w are the same storage as logical registers 8 to 15 of window w+1. Logical registers 16 to 23 are private to each window.
- R4: A write to logical register 0 is discarded, and register 0 always reads zero.
- R5: A read of a register in the same cycle that register is written returns the value held before the write. The new value is visible from the next cycle.
- R6: With no trap pending, a call raises the current-window pointer by one and a return lowers it by one.
- R7: A call made while NWIN-1 windows are resident raises the overflow trap and stall. It reports the oldest resident window (the saved-window pointer plus one) as the transfer window. It then shows that window's registers on the spill port at offsets 0 to 15, one offset per cycle. Offset k below 8 carries local k (logical 16+k), and offset 8+j carries incoming j (logical 8+j).
- R8: After the spill walk, the pointer holds until the spill-done strobe. On that strobe the saved-window pointer advances by one, the pending call completes and stall drops.
- R9: A return made while only the current window is resident raises the underflow trap and stall, and reports the saved-window pointer as the transfer window. While the trap is raised, a fill write at offset k loads that window's registers with the same layout as R7, and the pointer does not move.
- R10: On the fill-done strobe the saved-window pointer and the current-window pointer both move back by one, and stall drops.
- R11: A call or return strobe that arrives while stall is high has no effect. When call and return arrive together, the call is taken.
- R12: Both window pointers wrap modulo NWIN in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| rs1_i | input | 5 | Logical register number, read port 1 |
| rs2_i | input | 5 | Logical register number, read port 2 |
| rd_i | input | 5 | Logical register number, write port |
| we_i | input | 1 | Write enable |
| wdata_i | input | XLEN | Write data |
| rdata1_o | output | XLEN | Read data, port 1 |
| rdata2_o | output | XLEN | Read data, port 2 |
| cwp_o | output | log2(NWIN) | Current-window pointer |
| swp_o | output | log2(NWIN) | Saved-window pointer (next frame to restore) |
| stall_o | output | 1 | Call/return held while a trap is serviced |
| ovf_trap_o | output | 1 | Overflow trap raised |
| unf_trap_o | output | 1 | Underflow trap raised |
| xfer_win_o | output | log2(NWIN) | Physical window being spilled or filled |
| xfer_idx_o | output | 4 | Spill register offset |
| spill_valid_o | output | 1 | Spill data valid this cycle |
| spill_data_o | output | XLEN | Spill register value |
| spill_done_i | input | 1 | Spill transfer acknowledged |
| fill_we_i | input | 1 | Fill write strobe |
| fill_idx_i | input | 4 | Fill register offset |
| fill_data_i | input | XLEN | Fill data |
| fill_done_i | input | 1 | Fill transfer acknowledged |

## Verification
The bench builds the block with NWIN=4 and XLEN=16. With four windows, the third call in a row already reaches the resident limit, so the bench can trigger two overflow spills in a short run. The second spill takes the current-window pointer past NWIN-1 back to 0. The returns that follow wrap it downward and then reach an underflow fill. The narrower data keeps the distinct per-window patterns easy to check.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        WS_RUN        = 2'd0,
        WS_SPILL      = 2'd1,
        WS_SPILL_WAIT = 2'd2,
        WS_FILL       = 2'd3
    } win_state_t;

    // Logical register groups, each NGRP wide
    localparam int GRP_GLOBAL = 0;
    localparam int GRP_IN     = 1;
    localparam int GRP_LOCAL  = 2;
    localparam int GRP_OUT    = 3;

    function automatic int ring_inc(input int v, input int n);
        return (v == n - 1) ? 0 : v + 1;
    endfunction

    function automatic int ring_dec(input int v, input int n);
        return (v == 0) ? n - 1 : v - 1;
    endfunction

    // Physical layout: globals first, then per window a local bank and an out bank
    function automatic int local_base(input int win, input int ngrp);
        return ngrp + win * 2 * ngrp;
    endfunction

    function automatic int out_base(input int win, input int ngrp);
        return ngrp + win * 2 * ngrp + ngrp;
    endfunction

    function automatic int lreg_to_phys(input int lreg, input int cwp,
                                        input int nwin, input int ngrp);
        int grp;
        int off;
        grp = lreg / ngrp;
        off = lreg % ngrp;
        case (grp)
            GRP_GLOBAL: return off;
            GRP_IN:     return out_base(ring_dec(cwp, nwin), ngrp) + off;
            GRP_LOCAL:  return local_base(cwp, ngrp) + off;
            default:    return out_base(cwp, ngrp) + off;
        endcase
    endfunction

    // Spill/fill offset k: locals first, then the window's incoming group
    function automatic int xfer_to_phys(input int win, input int k,
                                        input int nwin, input int ngrp);
        if (k < ngrp)
            return local_base(win, ngrp) + k;
        return out_base(ring_dec(win, nwin), ngrp) + (k - ngrp);
    endfunction

endpackage

// File: rtl/regwin_xlate.sv
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int NGRP   = 8,
    parameter int LREG_W = $clog2(4 * NGRP),
    parameter int WIN_W  = $clog2(NWIN),
    parameter int PHYS_W = $clog2(NGRP + 2 * NGRP * NWIN)
) (
    input  logic [LREG_W-1:0] lreg_i,
    input  logic [WIN_W-1:0]  cwp_i,
    output logic [PHYS_W-1:0] phys_o
);
    always_comb begin
        phys_o = PHYS_W'(lreg_to_phys(int'(lreg_i), int'(cwp_i), NWIN, NGRP));
    end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int XLEN   = 32,
    parameter int NPHYS  = 136,
    parameter int NRD    = 3,
    parameter int PHYS_W = $clog2(NPHYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHYS_W-1:0] raddr_i [NRD],
    output logic [XLEN-1:0]   rdata_o [NRD],
    input  logic              wea_i,
    input  logic [PHYS_W-1:0] waddra_i,
    input  logic [XLEN-1:0]   wdataa_i,
    input  logic              web_i,
    input  logic [PHYS_W-1:0] waddrb_i,
    input  logic [XLEN-1:0]   wdatab_i
);
    logic [XLEN-1:0] mem [NPHYS];

    // Port B (fill) wins over port A; address 0 never takes a write
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else begin
            if (wea_i && waddra_i != '0)
                mem[waddra_i] <= wdataa_i;
            if (web_i && waddrb_i != '0)
                mem[waddrb_i] <= wdatab_i;
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            assign rdata_o[p] = mem[raddr_i[p]];
        end
    endgenerate

    p_zero_reg_r4: assert property (@(posedge clk) disable iff (rst)
        mem[0] == '0)
        else $error("register 0 changed");

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int NGRP   = 8,
    parameter int WIN_W  = $clog2(NWIN),
    parameter int XIDX_W = $clog2(2 * NGRP),
    parameter int LIVE_W = $clog2(NWIN) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              spill_done_i,
    input  logic              fill_done_i,
    output logic [WIN_W-1:0]  cwp_o,
    output logic [WIN_W-1:0]  swp_o,
    output logic              stall_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic              spill_valid_o,
    output logic [WIN_W-1:0]  xfer_win_o,
    output logic [XIDX_W-1:0] xfer_idx_o
);
    localparam int                LAST_IDX = 2 * NGRP - 1;
    localparam logic [LIVE_W-1:0] LIVE_MAX = LIVE_W'(NWIN - 1);
    localparam logic [LIVE_W-1:0] LIVE_ONE = LIVE_W'(1);

    win_state_t        state;
    logic [WIN_W-1:0]  cwp;
    logic [WIN_W-1:0]  oldest;
    logic [LIVE_W-1:0] live;
    logic [XIDX_W-1:0] cnt;

    logic [WIN_W-1:0] cwp_up, cwp_dn, old_up, old_dn;
    always_comb begin
        cwp_up = WIN_W'(ring_inc(int'(cwp), NWIN));
        cwp_dn = WIN_W'(ring_dec(int'(cwp), NWIN));
        old_up = WIN_W'(ring_inc(int'(oldest), NWIN));
        old_dn = WIN_W'(ring_dec(int'(oldest), NWIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WS_RUN;
            cwp    <= '0;
            oldest <= '0;
            live   <= LIVE_ONE;
            cnt    <= '0;
        end else begin
            case (state)
                WS_RUN: begin
                    if (call_i) begin
                        if (live == LIVE_MAX) begin
                            state <= WS_SPILL;
                            cnt   <= '0;
                        end else begin
                            cwp  <= cwp_up;
                            live <= live + LIVE_ONE;
                        end
                    end else if (ret_i) begin
                        if (live == LIVE_ONE) begin
                            state <= WS_FILL;
                        end else begin
                            cwp  <= cwp_dn;
                            live <= live - LIVE_ONE;
                        end
                    end
                end
                WS_SPILL: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == XIDX_W'(LAST_IDX))
                        state <= WS_SPILL_WAIT;
                end
                WS_SPILL_WAIT: begin
                    // oldest frame leaves, pending call enters: live unchanged
                    if (spill_done_i) begin
                        oldest <= old_up;
                        cwp    <= cwp_up;
                        state  <= WS_RUN;
                    end
                end
                default: begin
                    // restored frame enters, return leaves: live unchanged
                    if (fill_done_i) begin
                        oldest <= old_dn;
                        cwp    <= cwp_dn;
                        state  <= WS_RUN;
                    end
                end
            endcase
        end
    end

    assign cwp_o         = cwp;
    assign swp_o         = old_dn;
    assign stall_o       = (state != WS_RUN);
    assign ovf_o         = (state == WS_SPILL) || (state == WS_SPILL_WAIT);
    assign unf_o         = (state == WS_FILL);
    assign spill_valid_o = (state == WS_SPILL);
    assign xfer_win_o    = (state == WS_FILL) ? old_dn : oldest;
    assign xfer_idx_o    = cnt;

    p_live_range_r7: assert property (@(posedge clk) disable iff (rst)
        (live >= LIVE_ONE) && (live <= LIVE_MAX))
        else $error("resident count out of range");

    p_hold_cwp_r11: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !spill_done_i && !fill_done_i) |=> $stable(cwp_o))
        else $error("pointer moved while stalled");

    p_trap_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o))
        else $error("both traps raised");

    p_spill_walk_r7: assert property (@(posedge clk) disable iff (rst)
        (spill_valid_o && $past(spill_valid_o)) |->
            (xfer_idx_o == $past(xfer_idx_o) + 1'b1))
        else $error("spill offset skipped");

    p_spill_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_valid_o) |-> (xfer_idx_o == '0))
        else $error("spill walk did not start at 0");

    p_fill_commit_r10: assert property (@(posedge clk) disable iff (rst)
        (unf_o && fill_done_i) |=> (!stall_o && swp_o != $past(swp_o)))
        else $error("fill did not commit");

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int XLEN   = 32,
    parameter int NGRP   = 8,
    parameter int LREG_W = $clog2(4 * NGRP),
    parameter int WIN_W  = $clog2(NWIN),
    parameter int XIDX_W = $clog2(2 * NGRP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [LREG_W-1:0] rs1_i,
    input  logic [LREG_W-1:0] rs2_i,
    input  logic [LREG_W-1:0] rd_i,
    input  logic              we_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [XLEN-1:0]   rdata1_o,
    output logic [XLEN-1:0]   rdata2_o,
    output logic [WIN_W-1:0]  cwp_o,
    output logic [WIN_W-1:0]  swp_o,
    output logic              stall_o,
    output logic              ovf_trap_o,
    output logic              unf_trap_o,
    output logic [WIN_W-1:0]  xfer_win_o,
    output logic [XIDX_W-1:0] xfer_idx_o,
    output logic              spill_valid_o,
    output logic [XLEN-1:0]   spill_data_o,
    input  logic              spill_done_i,
    input  logic              fill_we_i,
    input  logic [XIDX_W-1:0] fill_idx_i,
    input  logic [XLEN-1:0]   fill_data_i,
    input  logic              fill_done_i
);
    localparam int NPHYS  = NGRP + 2 * NGRP * NWIN;
    localparam int PHYS_W = $clog2(NPHYS);
    localparam int NLOG   = 3;   // rs1, rs2, rd
    localparam int NRD    = 3;   // rs1, rs2, spill

    logic [WIN_W-1:0]  cwp;
    logic [WIN_W-1:0]  xfer_win;
    logic [XIDX_W-1:0] xfer_idx;
    logic              unf;

    logic [LREG_W-1:0] lreg [NLOG];
    logic [PHYS_W-1:0] preg [NLOG];
    logic [PHYS_W-1:0] raddr [NRD];
    logic [XLEN-1:0]   rdata [NRD];
    logic [PHYS_W-1:0] spill_addr, fill_addr;

    assign lreg[0] = rs1_i;
    assign lreg[1] = rs2_i;
    assign lreg[2] = rd_i;

    regwin_ctrl #(.NWIN(NWIN), .NGRP(NGRP)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .call_i       (call_i),
        .ret_i        (ret_i),
        .spill_done_i (spill_done_i),
        .fill_done_i  (fill_done_i),
        .cwp_o        (cwp),
        .swp_o        (swp_o),
        .stall_o      (stall_o),
        .ovf_o        (ovf_trap_o),
        .unf_o        (unf),
        .spill_valid_o(spill_valid_o),
        .xfer_win_o   (xfer_win),
        .xfer_idx_o   (xfer_idx)
    );

    generate
        for (genvar i = 0; i < NLOG; i++) begin : g_xl
            regwin_xlate #(.NWIN(NWIN), .NGRP(NGRP)) u_xl (
                .lreg_i(lreg[i]),
                .cwp_i (cwp),
                .phys_o(preg[i])
            );
        end
    endgenerate

    always_comb begin
        spill_addr = PHYS_W'(xfer_to_phys(int'(xfer_win), int'(xfer_idx), NWIN, NGRP));
        fill_addr  = PHYS_W'(xfer_to_phys(int'(xfer_win), int'(fill_idx_i), NWIN, NGRP));
    end

    assign raddr[0] = preg[0];
    assign raddr[1] = preg[1];
    assign raddr[2] = spill_addr;

    regwin_store #(.XLEN(XLEN), .NPHYS(NPHYS), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst     (rst),
        .raddr_i (raddr),
        .rdata_o (rdata),
        .wea_i   (we_i),
        .waddra_i(preg[2]),
        .wdataa_i(wdata_i),
        .web_i   (fill_we_i && unf),
        .waddrb_i(fill_addr),
        .wdatab_i(fill_data_i)
    );

    assign rdata1_o     = rdata[0];
    assign rdata2_o     = rdata[1];
    assign spill_data_o = rdata[2];
    assign cwp_o        = cwp;
    assign unf_trap_o   = unf;
    assign xfer_win_o   = xfer_win;
    assign xfer_idx_o   = xfer_idx;

    p_zero_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rs1_i == '0) |-> (rdata1_o == '0))
        else $error("register 0 read nonzero");

    p_ovf_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf_trap_o || unf_trap_o) |-> stall_o)
        else $error("trap without stall");

endmodule

// File: tb/regwin_file_bench.sv
`timescale 1ns/1ps
module regwin_file_bench;
    localparam int NWIN = 4;
    localparam int XLEN = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic call_i = 0, ret_i = 0, we_i = 0;
    logic [4:0] rs1_i = 0, rs2_i = 0, rd_i = 0;
    logic [XLEN-1:0] wdata_i = 0;
    logic [XLEN-1:0] rdata1_o, rdata2_o, spill_data_o;
    logic [1:0] cwp_o, swp_o, xfer_win_o;
    logic [3:0] xfer_idx_o;
    logic stall_o, ovf_trap_o, unf_trap_o, spill_valid_o;
    logic spill_done_i = 0, fill_we_i = 0, fill_done_i = 0;
    logic [3:0] fill_idx_i = 0;
    logic [XLEN-1:0] fill_data_i = 0;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 0;

    typedef struct { int idx; int data; } spill_item_t;
    spill_item_t spill_q[$];

    always #5 clk = ~clk;

    regwin_file #(.NWIN(NWIN), .XLEN(XLEN)) u_regwin_file (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .rd_i(rd_i), .we_i(we_i), .wdata_i(wdata_i),
        .rdata1_o(rdata1_o), .rdata2_o(rdata2_o), .cwp_o(cwp_o), .swp_o(swp_o),
        .stall_o(stall_o), .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o),
        .xfer_win_o(xfer_win_o), .xfer_idx_o(xfer_idx_o), .spill_valid_o(spill_valid_o),
        .spill_data_o(spill_data_o), .spill_done_i(spill_done_i), .fill_we_i(fill_we_i),
        .fill_idx_i(fill_idx_i), .fill_data_i(fill_data_i), .fill_done_i(fill_done_i)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int r, input int d);
        we_i = 1; rd_i = 5'(r); wdata_i = XLEN'(d);
        tick();
        we_i = 0;
    endtask

    task automatic rdchk(input string req, input int r, input int exp);
        rs1_i = 5'(r); rs2_i = 5'(r);
        #1;
        chk(req, int'(rdata1_o), exp);
        chk(req, int'(rdata2_o), exp);
    endtask

    task automatic pulse_call();
        call_i = 1; tick(); call_i = 0;
    endtask

    task automatic pulse_ret();
        ret_i = 1; tick(); ret_i = 0;
    endtask

    // Spill monitor: scoreboard of expected spill beats (R7)
    always @(negedge clk) begin
        if (!rst && spill_valid_o) begin
            if (spill_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R7: unexpected spill beat idx %0d got 0x%0h expected none",
                         xfer_idx_o, spill_data_o);
            end else begin
                spill_item_t it;
                it = spill_q.pop_front();
                chk("R7 spill idx", int'(xfer_idx_o), it.idx);
                chk("R7 spill data", int'(spill_data_o), it.data);
            end
        end
    end

    task automatic push_spill(input int loc_base, input int in_base);
        for (int k = 0; k < 16; k++) begin
            spill_item_t it;
            it.idx = k;
            it.data = (k < 8) ? loc_base + k : in_base + (k - 8);
            spill_q.push_back(it);
        end
    endtask

    task automatic overflow(input int exp_win, input int exp_cwp, input int exp_swp);
        pulse_call();
        chk("R7 ovf trap", int'(ovf_trap_o), 1);
        chk("R7 stall", int'(stall_o), 1);
        chk("R7 xfer win", int'(xfer_win_o), exp_win);
        pulse_ret();                     // R11: ignored during stall
        while (spill_valid_o) tick();
        chk("R8 hold ovf", int'(ovf_trap_o), 1);
        chk("R8 cwp held", int'(cwp_o), (exp_cwp + NWIN - 1) % NWIN);
        chk("R7 all beats", spill_q.size(), 0);
        spill_done_i = 1; tick(); spill_done_i = 0;
        chk("R8 cwp after", int'(cwp_o), exp_cwp);
        chk("R8 swp after", int'(swp_o), exp_swp);
        chk("R8 stall drop", int'(stall_o), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 cwp", int'(cwp_o), 0);
        chk("R1 swp", int'(swp_o), NWIN - 1);
        chk("R1 stall", int'(stall_o), 0);
        chk("R1 traps", int'(ovf_trap_o | unf_trap_o), 0);
        rdchk("R1 reg", 17, 0);

        // R5 read during write
        we_i = 1; rd_i = 16; wdata_i = 16'h00AA; rs1_i = 16; rs2_i = 16;
        #1 chk("R5 old value", int'(rdata1_o), 0);
        tick(); we_i = 0;
        rdchk("R5 new value", 16, 16'h00AA);

        // R4 register 0
        wr(0, 16'hBEEF);
        rdchk("R4 zero", 0, 0);

        // window 0 contents
        wr(1, 16'h1111);
        for (int k = 0; k < 8; k++) begin
            wr(16 + k, 16'h0100 + k);
            wr(24 + k, 16'h0200 + k);
            wr(8 + k, 16'h0300 + k);
        end

        pulse_call();
        chk("R6 call", int'(cwp_o), 1);
        rdchk("R2 global", 1, 16'h1111);
        rdchk("R3 overlap", 8, 16'h0200);
        rdchk("R3 overlap", 15, 16'h0207);
        rdchk("R3 private", 16, 0);
        for (int k = 0; k < 8; k++) begin
            wr(16 + k, 16'h1100 + k);
            wr(24 + k, 16'h1200 + k);
        end

        pulse_call();
        chk("R6 call", int'(cwp_o), 2);
        for (int k = 0; k < 8; k++) begin
            wr(16 + k, 16'h2100 + k);
            wr(24 + k, 16'h2200 + k);
        end

        // first overflow: oldest window 0
        push_spill(16'h0100, 16'h0300);
        overflow(0, 3, 0);
        rdchk("R2 global w3", 1, 16'h1111);
        rdchk("R3 w3 in", 8, 16'h2200);

        // second overflow: oldest window 1, pointer wraps 3 -> 0
        push_spill(16'h1100, 16'h0200);
        overflow(1, 0, 1);
        chk("R12 wrap up", int'(cwp_o), 0);

        // returns, wrapping down
        pulse_ret();
        chk("R12 wrap down", int'(cwp_o), 3);
        pulse_ret();
        chk("R6 ret", int'(cwp_o), 2);
        rdchk("R6 locals w2", 16, 16'h2100);

        // underflow into window 1
        pulse_ret();
        chk("R9 unf trap", int'(unf_trap_o), 1);
        chk("R9 stall", int'(stall_o), 1);
        chk("R9 xfer win", int'(xfer_win_o), 1);
        chk("R9 xfer is swp", int'(xfer_win_o), int'(swp_o));
        pulse_call();                   // R11: ignored during stall
        for (int k = 0; k < 16; k++) begin
            fill_we_i = 1; fill_idx_i = 4'(k);
            fill_data_i = XLEN'((k < 8) ? 16'h5100 + k : 16'h5200 + k - 8);
            tick();
        end
        fill_we_i = 0;
        chk("R9 cwp held", int'(cwp_o), 2);
        chk("R11 no call", int'(unf_trap_o), 1);
        fill_done_i = 1; tick(); fill_done_i = 0;
        chk("R10 cwp", int'(cwp_o), 1);
        chk("R10 swp", int'(swp_o), 0);
        chk("R10 stall", int'(stall_o), 0);
        rdchk("R9 filled local", 16, 16'h5100);
        rdchk("R9 filled local", 23, 16'h5107);
        rdchk("R9 filled in", 8, 16'h5200);
        rdchk("R3 outs kept", 24, 16'h1200);

        // R11 simultaneous strobes: call wins
        call_i = 1; ret_i = 1; tick(); call_i = 0; ret_i = 0;
        chk("R11 call wins", int'(cwp_o), 2);
        rdchk("R11 locals w2", 16, 16'h2100);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done_flag) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule